// File: doc/BRIEF.md
# Hardwired CPU Control Sequencer

This block is the hardwired finite-state controller of a small accumulator-free register CPU. The datapath around it has two internal buses, so the memory address register and the memory data register can be loaded in the same cycle. The controller issues one set of datapath control strobes per clock. It fetches an instruction word, decodes its fixed fields and steps through a small set of shared execution states for memory loads and stores (absolute or register-addressed), register move, add, increment, compare, conditional jump, subroutine call and return. The datapath, register file and memory are outside the block.

Memory accesses sit in a wait state until the memory signals ready. That costs no extra cycles on a cache hit and many cycles on a miss. The controller exposes its current state as a trace code and raises a done strobe in the last cycle of every instruction, so instruction latency can be measured at the ports. Register-file writeback states are shared between instructions. This works because the destination of a memory load always lies in the first register field and the destination of every ALU result always lies in the second. Call and return use a fixed stack-pointer register.

States and transitions: `S_FETCH`→`S_FWAIT`; `S_FWAIT` holds until ready, then →`S_DECODE`; `S_DECODE` branches by opcode to `S_LD_ABS`, `S_LD_REG`, `S_ST_ABS`, `S_ST_REG`, `S_MOV`, `S_ADD`, `S_INC`, `S_CMP`, `S_JTEST`, `S_SPDEC` or `S_POP`, and an undefined code goes back to `S_FETCH`. `S_LD_ABS`/`S_LD_REG`/`S_POP`→`S_RWAIT`. `S_RWAIT` holds until ready, then goes →`S_RETPC` on a return and →`S_WB_MEM` otherwise. `S_WB_MEM`→`S_FETCH`. `S_ST_ABS`/`S_ST_REG`/`S_PUSH`→`S_WWAIT`. `S_WWAIT` holds until ready, then →`S_WDONE`. `S_WDONE` goes →`S_JUMP` on a call and →`S_FETCH` otherwise. `S_MOV`/`S_ADD`/`S_INC`→`S_WB_ALU`→`S_FETCH`. `S_CMP`→`S_FETCH`. `S_JTEST` goes →`S_JUMP` when the condition flag is set and →`S_FETCH` when it is clear. `S_JUMP`→`S_FETCH`. `S_SPDEC`→`S_SPWB`. `S_SPWB` goes →`S_PUSH` on a call and →`S_FETCH` otherwise. `S_RETPC`→`S_SPINC`→`S_SPWB`.

Top module: `hw_ctl_fsm`

## Requirements
- R1: An asynchronous active-low reset puts the machine in the first fetch state, trace code 0, from any state (including a memory wait). While reset is held, no memory write and no register write are strobed. The next instruction after release runs its full normal cycle count.
- R2: Fetch loads MAR from PC (`mar_sel` 0), waits for a read, then strobes IR load and PC increment exactly once per instruction, and decodes `mdr_fields`. The field layout is: opcode in the top 4 bits, then register fields A, B and C of 3 bits each from high to low. Opcodes: 0 load, 1 store, 2 register load, 3 register store, 4 move, 5 add, 6 increment, 7 compare, 8 jump, 9 call, 10 return.
- R3: Every memory read or write state holds until `mem_ready` is high. Each cycle that ready is late adds exactly one cycle to the instruction.
- R4: Load (0) and register load (2) take 6 cycles with zero wait. Both write field A from MDR (`rf_wr_src` 0) in one shared writeback state. Register load drives its address from register field B.
- R5: Store (1) and register store (3) take 6 cycles with zero wait. Each loads MAR and MDR in one cycle, with data from field A on read port B (`mdr_sel` 0). The address comes from the address field (`mar_sel` 1) for store, or from register field B on read port A (`mar_sel` 2) for register store. Neither writes a register.
- R6: Move (4), add (5) and increment (6) take 5 cycles with zero wait. Each latches an ALU result in T and writes it to field B (`rf_wr_src` 1) in one shared writeback state.
- R7: Compare (7) takes 4 cycles with zero wait, loads the condition flag once, and writes no register.
- R8: Jump (8) takes 5 cycles and loads PC once when `cc_in` is set. It takes 4 cycles and never loads PC when `cc_in` is clear.
- R9: Call (9) takes 9 cycles with zero wait. It writes the decremented stack pointer (register 7) back from T, then loads MAR from register 7 and MDR from PC (`mdr_sel` 1) in one cycle, writes memory, and loads PC once.
- R10: Return (10) takes 8 cycles with zero wait. It reads memory at register 7, loads PC from MDR, and writes the incremented stack pointer (register 7) back from T.
- R11: An undefined opcode (11 to 15) returns to fetch straight after decode: 3 cycles with zero wait, with no register write and no PC load.
- R12: `instr_done` is high in exactly the last cycle of each instruction, and the following cycle is the fetch state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_ready | input | 1 | Memory access complete this cycle |
| cc_in | input | 1 | Condition flag from the datapath |
| mdr_fields | input | OP_W+3*REG_W | Opcode and register fields of the word in MDR |
| mar_ld | output | 1 | Load MAR |
| mar_sel | output | 2 | MAR source: 0 PC, 1 address field, 2 read port A |
| mdr_ld | output | 1 | Load MDR from the bus |
| mdr_sel | output | 1 | MDR source: 0 read port B, 1 PC |
| ir_ld | output | 1 | Load IR from MDR |
| pc_inc | output | 1 | Increment PC |
| pc_ld | output | 1 | Load PC |
| pc_sel | output | 1 | PC source: 0 address field, 1 MDR |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| alu_fn | output | 3 | ALU function: 0 none, 1 pass, 2 add, 3 subtract, 4 plus one, 5 minus one |
| t_ld | output | 1 | Latch the ALU result in T |
| cc_ld | output | 1 | Latch the condition flag |
| rf_we | output | 1 | Register file write |
| rf_wr_src | output | 1 | Write data: 0 MDR, 1 T |
| rf_wr_idx | output | REG_W | Register written |
| rf_a_idx | output | REG_W | Read port A select |
| rf_b_idx | output | REG_W | Read port B select |
| state_code | output | 5 | Current state trace, fetch is 0 |
| instr_done | output | 1 | Last cycle of the current instruction |

## Verification
The properties assume that `mem_ready` is only meaningful during a read or write wait state. They also assume that `mdr_fields` is stable in the decode cycle and `cc_in` is stable in the jump-test cycle. The stimulus meets these assumptions: a memory model raises ready only after a chosen number of wait cycles inside an access, and drops it at once outside one. Instruction words and the flag are changed only once per instruction, during its first fetch cycle. Reset is also pulled in the middle of a long write wait to show the machine abandons it cleanly.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    typedef enum logic [4:0] {
        S_FETCH  = 5'd0,
        S_FWAIT  = 5'd1,
        S_DECODE = 5'd2,
        S_LD_ABS = 5'd3,
        S_LD_REG = 5'd4,
        S_RWAIT  = 5'd5,
        S_WB_MEM = 5'd6,
        S_ST_ABS = 5'd7,
        S_ST_REG = 5'd8,
        S_WWAIT  = 5'd9,
        S_WDONE  = 5'd10,
        S_MOV    = 5'd11,
        S_ADD    = 5'd12,
        S_INC    = 5'd13,
        S_WB_ALU = 5'd14,
        S_CMP    = 5'd15,
        S_JTEST  = 5'd16,
        S_JUMP   = 5'd17,
        S_SPDEC  = 5'd18,
        S_SPWB   = 5'd19,
        S_PUSH   = 5'd20,
        S_POP    = 5'd21,
        S_RETPC  = 5'd22,
        S_SPINC  = 5'd23
    } state_t;

    typedef enum logic [3:0] {
        OP_LD   = 4'd0,
        OP_ST   = 4'd1,
        OP_LDR  = 4'd2,
        OP_STR  = 4'd3,
        OP_MOV  = 4'd4,
        OP_ADD  = 4'd5,
        OP_INC  = 4'd6,
        OP_CMP  = 4'd7,
        OP_JMP  = 4'd8,
        OP_CALL = 4'd9,
        OP_RET  = 4'd10,
        OP_BAD  = 4'd15
    } op_t;

    typedef enum logic [2:0] {
        ALU_NONE = 3'd0,
        ALU_PASS = 3'd1,
        ALU_ADD  = 3'd2,
        ALU_SUB  = 3'd3,
        ALU_INC  = 3'd4,
        ALU_DEC  = 3'd5
    } alu_t;

    localparam logic [1:0] MAR_FROM_PC   = 2'd0;
    localparam logic [1:0] MAR_FROM_ADDR = 2'd1;
    localparam logic [1:0] MAR_FROM_REG  = 2'd2;

    localparam int NUM_OPS = 11;

endpackage

// File: rtl/ctl_decode.sv
module ctl_decode
    import ctl_pkg::*;
#(
    parameter int OP_W  = 4,
    parameter int REG_W = 3
) (
    input  logic [OP_W+3*REG_W-1:0] fields,
    output op_t                     op,
    output logic [REG_W-1:0]        ra,
    output logic [REG_W-1:0]        rb,
    output logic [REG_W-1:0]        rc
);
    localparam int RC_LSB = 0;
    localparam int RB_LSB = REG_W;
    localparam int RA_LSB = 2 * REG_W;
    localparam int OP_LSB = 3 * REG_W;

    logic [OP_W-1:0] code;

    assign code = fields[OP_LSB +: OP_W];
    assign ra   = fields[RA_LSB +: REG_W];
    assign rb   = fields[RB_LSB +: REG_W];
    assign rc   = fields[RC_LSB +: REG_W];

    // codes past the last defined opcode fall back to the refetch path
    always_comb begin
        if (code < OP_W'(NUM_OPS)) op = op_t'(code[3:0]);
        else                       op = OP_BAD;
    end
endmodule

// File: rtl/ctl_next.sv
module ctl_next
    import ctl_pkg::*;
(
    input  state_t state,
    input  op_t    op_dec,
    input  op_t    op_q,
    input  logic   mem_ready,
    input  logic   cc_in,
    output state_t state_n
);
    always_comb begin
        state_n = state;
        unique case (state)
            S_FETCH:  state_n = S_FWAIT;
            S_FWAIT:  if (mem_ready) state_n = S_DECODE;
            S_DECODE: begin
                unique case (op_dec)
                    OP_LD:   state_n = S_LD_ABS;
                    OP_LDR:  state_n = S_LD_REG;
                    OP_ST:   state_n = S_ST_ABS;
                    OP_STR:  state_n = S_ST_REG;
                    OP_MOV:  state_n = S_MOV;
                    OP_ADD:  state_n = S_ADD;
                    OP_INC:  state_n = S_INC;
                    OP_CMP:  state_n = S_CMP;
                    OP_JMP:  state_n = S_JTEST;
                    OP_CALL: state_n = S_SPDEC;
                    OP_RET:  state_n = S_POP;
                    default: state_n = S_FETCH;
                endcase
            end
            S_LD_ABS, S_LD_REG, S_POP: state_n = S_RWAIT;
            S_RWAIT: begin
                if (mem_ready) state_n = (op_q == OP_RET) ? S_RETPC : S_WB_MEM;
            end
            S_WB_MEM: state_n = S_FETCH;
            S_ST_ABS, S_ST_REG, S_PUSH: state_n = S_WWAIT;
            S_WWAIT:  if (mem_ready) state_n = S_WDONE;
            S_WDONE:  state_n = (op_q == OP_CALL) ? S_JUMP : S_FETCH;
            S_MOV, S_ADD, S_INC: state_n = S_WB_ALU;
            S_WB_ALU: state_n = S_FETCH;
            S_CMP:    state_n = S_FETCH;
            S_JTEST:  state_n = cc_in ? S_JUMP : S_FETCH;
            S_JUMP:   state_n = S_FETCH;
            S_SPDEC:  state_n = S_SPWB;
            S_SPWB:   state_n = (op_q == OP_CALL) ? S_PUSH : S_FETCH;
            S_RETPC:  state_n = S_SPINC;
            S_SPINC:  state_n = S_SPWB;
            default:  state_n = S_FETCH;
        endcase
    end
endmodule

// File: rtl/ctl_outputs.sv
module ctl_outputs
    import ctl_pkg::*;
#(
    parameter int REG_W  = 3,
    parameter int SP_IDX = 7
) (
    input  state_t           state,
    input  logic [REG_W-1:0] ra,
    input  logic [REG_W-1:0] rb,
    input  logic [REG_W-1:0] rc,
    output logic             mar_ld,
    output logic [1:0]       mar_sel,
    output logic             mdr_ld,
    output logic             mdr_sel,
    output logic             ir_ld,
    output logic             pc_inc,
    output logic             pc_ld,
    output logic             pc_sel,
    output logic             mem_rd,
    output logic             mem_wr,
    output alu_t             alu_fn,
    output logic             t_ld,
    output logic             cc_ld,
    output logic             rf_we,
    output logic             rf_wr_src,
    output logic [REG_W-1:0] rf_wr_idx,
    output logic [REG_W-1:0] rf_a_idx,
    output logic [REG_W-1:0] rf_b_idx
);
    localparam logic [REG_W-1:0] SP = REG_W'(SP_IDX);

    always_comb begin
        mar_ld    = 1'b0;
        mar_sel   = MAR_FROM_PC;
        mdr_ld    = 1'b0;
        mdr_sel   = 1'b0;
        ir_ld     = 1'b0;
        pc_inc    = 1'b0;
        pc_ld     = 1'b0;
        pc_sel    = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        alu_fn    = ALU_NONE;
        t_ld      = 1'b0;
        cc_ld     = 1'b0;
        rf_we     = 1'b0;
        rf_wr_src = 1'b0;
        rf_wr_idx = '0;
        rf_a_idx  = '0;
        rf_b_idx  = '0;
        unique case (state)
            S_FETCH:  mar_ld = 1'b1;
            S_FWAIT:  mem_rd = 1'b1;
            S_DECODE: begin ir_ld = 1'b1; pc_inc = 1'b1; end
            S_LD_ABS: begin mar_ld = 1'b1; mar_sel = MAR_FROM_ADDR; end
            S_LD_REG: begin mar_ld = 1'b1; mar_sel = MAR_FROM_REG; rf_a_idx = rb; end
            S_RWAIT:  mem_rd = 1'b1;
            S_WB_MEM: begin rf_we = 1'b1; rf_wr_src = 1'b0; rf_wr_idx = ra; end
            S_ST_ABS: begin
                mar_ld = 1'b1; mar_sel = MAR_FROM_ADDR;
                mdr_ld = 1'b1; rf_b_idx = ra;
            end
            S_ST_REG: begin
                mar_ld = 1'b1; mar_sel = MAR_FROM_REG; rf_a_idx = rb;
                mdr_ld = 1'b1; rf_b_idx = ra;
            end
            S_WWAIT:  mem_wr = 1'b1;
            S_WDONE:  ;
            S_MOV:    begin rf_a_idx = rc; alu_fn = ALU_PASS; t_ld = 1'b1; end
            S_ADD:    begin rf_a_idx = rb; rf_b_idx = rc; alu_fn = ALU_ADD; t_ld = 1'b1; end
            S_INC:    begin rf_a_idx = rb; alu_fn = ALU_INC; t_ld = 1'b1; end
            S_WB_ALU: begin rf_we = 1'b1; rf_wr_src = 1'b1; rf_wr_idx = rb; end
            S_CMP:    begin rf_a_idx = rb; rf_b_idx = rc; alu_fn = ALU_SUB; cc_ld = 1'b1; end
            S_JTEST:  ;
            S_JUMP:   begin pc_ld = 1'b1; pc_sel = 1'b0; end
            S_SPDEC:  begin rf_a_idx = SP; alu_fn = ALU_DEC; t_ld = 1'b1; end
            S_SPWB:   begin rf_we = 1'b1; rf_wr_src = 1'b1; rf_wr_idx = SP; end
            S_PUSH:   begin
                mar_ld = 1'b1; mar_sel = MAR_FROM_REG; rf_a_idx = SP;
                mdr_ld = 1'b1; mdr_sel = 1'b1;
            end
            S_POP:    begin mar_ld = 1'b1; mar_sel = MAR_FROM_REG; rf_a_idx = SP; end
            S_RETPC:  begin pc_ld = 1'b1; pc_sel = 1'b1; end
            S_SPINC:  begin rf_a_idx = SP; alu_fn = ALU_INC; t_ld = 1'b1; end
            default:  ;
        endcase
    end
endmodule

// File: rtl/hw_ctl_fsm.sv
module hw_ctl_fsm
    import ctl_pkg::*;
#(
    parameter int OP_W   = 4,
    parameter int REG_W  = 3,
    parameter int SP_IDX = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mem_ready,
    input  logic                    cc_in,
    input  logic [OP_W+3*REG_W-1:0] mdr_fields,
    output logic                    mar_ld,
    output logic [1:0]              mar_sel,
    output logic                    mdr_ld,
    output logic                    mdr_sel,
    output logic                    ir_ld,
    output logic                    pc_inc,
    output logic                    pc_ld,
    output logic                    pc_sel,
    output logic                    mem_rd,
    output logic                    mem_wr,
    output logic [2:0]              alu_fn,
    output logic                    t_ld,
    output logic                    cc_ld,
    output logic                    rf_we,
    output logic                    rf_wr_src,
    output logic [REG_W-1:0]        rf_wr_idx,
    output logic [REG_W-1:0]        rf_a_idx,
    output logic [REG_W-1:0]        rf_b_idx,
    output logic [4:0]              state_code,
    output logic                    instr_done
);
    state_t           state, state_n;
    op_t              op_dec, op_q;
    logic [REG_W-1:0] ra_d, rb_d, rc_d;
    logic [REG_W-1:0] ra_q, rb_q, rc_q;
    alu_t             alu_w;

    ctl_decode #(.OP_W(OP_W), .REG_W(REG_W)) u_decode (
        .fields (mdr_fields),
        .op     (op_dec),
        .ra     (ra_d),
        .rb     (rb_d),
        .rc     (rc_d)
    );

    ctl_next u_next (
        .state     (state),
        .op_dec    (op_dec),
        .op_q      (op_q),
        .mem_ready (mem_ready),
        .cc_in     (cc_in),
        .state_n   (state_n)
    );

    // state register with the instruction fields captured at decode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_FETCH;
            op_q  <= OP_BAD;
            ra_q  <= '0;
            rb_q  <= '0;
            rc_q  <= '0;
        end else begin
            state <= state_n;
            if (state == S_DECODE) begin
                op_q <= op_dec;
                ra_q <= ra_d;
                rb_q <= rb_d;
                rc_q <= rc_d;
            end
        end
    end

    ctl_outputs #(.REG_W(REG_W), .SP_IDX(SP_IDX)) u_outputs (
        .state     (state),
        .ra        (ra_q),
        .rb        (rb_q),
        .rc        (rc_q),
        .mar_ld    (mar_ld),
        .mar_sel   (mar_sel),
        .mdr_ld    (mdr_ld),
        .mdr_sel   (mdr_sel),
        .ir_ld     (ir_ld),
        .pc_inc    (pc_inc),
        .pc_ld     (pc_ld),
        .pc_sel    (pc_sel),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .alu_fn    (alu_w),
        .t_ld      (t_ld),
        .cc_ld     (cc_ld),
        .rf_we     (rf_we),
        .rf_wr_src (rf_wr_src),
        .rf_wr_idx (rf_wr_idx),
        .rf_a_idx  (rf_a_idx),
        .rf_b_idx  (rf_b_idx)
    );

    assign alu_fn     = alu_w;
    assign state_code = state;
    assign instr_done = (state_n == S_FETCH);
endmodule

// File: rtl/ctl_fsm_chk.sv
module ctl_fsm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mem_ready,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       mar_ld,
    input logic       mdr_ld,
    input logic       pc_ld,
    input logic       pc_sel,
    input logic       cc_ld,
    input logic       rf_we,
    input logic       rf_wr_src,
    input logic       instr_done,
    input logic [4:0] state_code
);
    a_r3_read_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ready) |=> (mem_rd && state_code == $past(state_code)));

    a_r3_write_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ready) |=> mem_wr);

    a_r4_mem_wb_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && !rf_wr_src) |-> $past(mem_rd));

    a_r5_merged_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mar_ld && mdr_ld) |=> mem_wr);

    a_r7_compare_ends: assert property (@(posedge clk) disable iff (!rst_n)
        cc_ld |-> instr_done);

    a_r8_jump_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_ld && !pc_sel) |-> instr_done);

    a_r12_done_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |=> (state_code == 5'd0));
endmodule

bind hw_ctl_fsm ctl_fsm_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_ready  (mem_ready),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mar_ld     (mar_ld),
    .mdr_ld     (mdr_ld),
    .pc_ld      (pc_ld),
    .pc_sel     (pc_sel),
    .cc_ld      (cc_ld),
    .rf_we      (rf_we),
    .rf_wr_src  (rf_wr_src),
    .instr_done (instr_done),
    .state_code (state_code)
);

// File: tb/hw_ctl_fsm_test.sv
`timescale 1ns/1ps
module hw_ctl_fsm_test;

    typedef struct packed {
        int lat; int we_cnt; int widx; int wsrc; int merged;
        int msel; int aidx; int bidx; int mdsel; int pcld; int ccld;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_ready = 1'b0;
    logic        cc_in = 1'b0;
    logic [12:0] mdr_fields = '0;
    logic        mar_ld, mdr_ld, mdr_sel, ir_ld, pc_inc, pc_ld, pc_sel;
    logic        mem_rd, mem_wr, t_ld, cc_ld, rf_we, rf_wr_src, instr_done;
    logic [1:0]  mar_sel;
    logic [2:0]  alu_fn, rf_wr_idx, rf_a_idx, rf_b_idx;
    logic [4:0]  state_code;

    int checks = 0;
    int failures = 0;
    int done_seen = 0;
    int wait_cfg = 0;
    bit finished = 1'b0;
    exp_t  q_exp[$];
    string q_req[$];

    always #5 clk = ~clk;

    hw_ctl_fsm uut (
        .clk(clk), .rst_n(rst_n), .mem_ready(mem_ready), .cc_in(cc_in),
        .mdr_fields(mdr_fields), .mar_ld(mar_ld), .mar_sel(mar_sel),
        .mdr_ld(mdr_ld), .mdr_sel(mdr_sel), .ir_ld(ir_ld), .pc_inc(pc_inc),
        .pc_ld(pc_ld), .pc_sel(pc_sel), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .alu_fn(alu_fn), .t_ld(t_ld), .cc_ld(cc_ld), .rf_we(rf_we),
        .rf_wr_src(rf_wr_src), .rf_wr_idx(rf_wr_idx), .rf_a_idx(rf_a_idx),
        .rf_b_idx(rf_b_idx), .state_code(state_code), .instr_done(instr_done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // memory model: ready after wait_cfg idle cycles inside an access
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_rd || mem_wr) begin
                mem_ready = (cnt >= wait_cfg);
                cnt++;
            end else begin
                mem_ready = 1'b0;
                cnt = 0;
            end
        end
    end

    // monitor: gathers per-instruction activity and compares on done
    initial begin
        int cyc = 0, we = 0, widx = -1, wsrc = -1, mg = 0, msel = -1;
        int aidx = -1, bidx = -1, mds = -1, pcl = 0, ccl = 0, pci = 0;
        exp_t e;
        string r;
        forever begin
            @(negedge clk);
            #2;
            if (!rst_n) begin
                cyc = 0; we = 0; mg = 0; pcl = 0; ccl = 0; pci = 0;
                continue;
            end
            cyc++;
            if (rf_we) begin we++; widx = rf_wr_idx; wsrc = rf_wr_src; end
            if (mar_ld && mdr_ld) begin
                mg++; msel = mar_sel; aidx = rf_a_idx; bidx = rf_b_idx; mds = mdr_sel;
            end
            if (pc_ld) pcl++;
            if (cc_ld) ccl++;
            if (pc_inc) pci++;
            if (instr_done) begin
                if (q_exp.size() == 0) begin
                    chk("R12", "unexpected done", 1, 0);
                end else begin
                    e = q_exp.pop_front();
                    r = q_req.pop_front();
                    chk(r, "latency", cyc, e.lat);
                    chk(r, "reg writes", we, e.we_cnt);
                    if (e.we_cnt > 0) begin
                        chk(r, "write index", widx, e.widx);
                        chk(r, "write source", wsrc, e.wsrc);
                    end
                    chk(r, "merged MAR+MDR cycles", mg, e.merged);
                    if (e.merged > 0) begin
                        chk(r, "MAR source", msel, e.msel);
                        chk(r, "MDR source", mds, e.mdsel);
                        if (e.aidx >= 0) chk(r, "port A index", aidx, e.aidx);
                        if (e.bidx >= 0) chk(r, "port B index", bidx, e.bidx);
                    end
                    chk(r, "PC loads", pcl, e.pcld);
                    chk(r, "CC loads", ccl, e.ccld);
                    chk("R2", "PC increments", pci, 1);
                end
                done_seen++;
                cyc = 0; we = 0; mg = 0; pcl = 0; ccl = 0; pci = 0;
            end
        end
    end

    // driver: predicts the outcome from the requirements and starts one instruction
    task automatic issue(input string req, input int op, input int ra, input int rb,
                         input int rc, input bit cc, input int w);
        exp_t e;
        int acc;
        int tgt;
        e = '0;
        e.widx = -1; e.wsrc = -1; e.msel = -1; e.aidx = -1; e.bidx = -1; e.mdsel = -1;
        acc = (op <= 3 || op == 9 || op == 10) ? 2 : 1;
        case (op)
            0, 2:    begin e.lat = 6; e.we_cnt = 1; e.widx = ra; e.wsrc = 0; end
            1:       begin e.lat = 6; e.merged = 1; e.msel = 1; e.bidx = ra; e.mdsel = 0; end
            3:       begin e.lat = 6; e.merged = 1; e.msel = 2; e.aidx = rb; e.bidx = ra; e.mdsel = 0; end
            4, 5, 6: begin e.lat = 5; e.we_cnt = 1; e.widx = rb; e.wsrc = 1; end
            7:       begin e.lat = 4; e.ccld = 1; end
            8:       begin e.lat = cc ? 5 : 4; e.pcld = cc ? 1 : 0; end
            9:       begin
                e.lat = 9; e.we_cnt = 1; e.widx = 7; e.wsrc = 1;
                e.merged = 1; e.msel = 2; e.aidx = 7; e.mdsel = 1; e.pcld = 1;
            end
            10:      begin e.lat = 8; e.we_cnt = 1; e.widx = 7; e.wsrc = 1; e.pcld = 1; end
            default: e.lat = 3;
        endcase
        e.lat = e.lat + w * acc;
        q_exp.push_back(e);
        q_req.push_back(req);
        cc_in = cc;
        wait_cfg = w;
        mdr_fields = {4'(op), 3'(ra), 3'(rb), 3'(rc)};
        tgt = done_seen + 1;
        while (done_seen < tgt) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R12 watchdog actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        chk("R1", "state in reset", state_code, 0);
        chk("R1", "mem write in reset", mem_wr, 0);
        chk("R1", "reg write in reset", rf_we, 0);
        chk("R2", "fetch loads MAR", mar_ld, 1);
        chk("R2", "fetch MAR from PC", mar_sel, 0);
        @(negedge clk);
        #1;
        rst_n = 1'b1;

        // zero-wait pass over every instruction
        issue("R4", 0, 3, 1, 2, 1'b0, 0);
        issue("R5", 1, 5, 2, 0, 1'b0, 0);
        issue("R4", 2, 6, 4, 1, 1'b0, 0);
        issue("R5", 3, 2, 6, 3, 1'b0, 0);
        issue("R6", 4, 1, 5, 3, 1'b0, 0);
        issue("R6", 5, 0, 2, 6, 1'b0, 0);
        issue("R6", 6, 4, 3, 0, 1'b0, 0);
        issue("R7", 7, 0, 1, 2, 1'b1, 0);
        issue("R8", 8, 0, 0, 0, 1'b1, 0);
        issue("R8", 8, 0, 0, 0, 1'b0, 0);
        issue("R9", 9, 0, 0, 0, 1'b0, 0);
        issue("R10", 10, 0, 0, 0, 1'b0, 0);
        issue("R11", 15, 7, 7, 7, 1'b1, 0);
        issue("R11", 11, 1, 2, 3, 1'b0, 0);

        // slow memory: every access stretched
        issue("R3", 0, 7, 0, 0, 1'b0, 3);
        issue("R3", 3, 1, 7, 0, 1'b0, 2);
        issue("R3", 9, 0, 0, 0, 1'b0, 4);
        issue("R3", 10, 0, 0, 0, 1'b0, 1);
        issue("R3", 5, 0, 6, 5, 1'b0, 12);
        issue("R3", 8, 0, 0, 0, 1'b1, 5);

        // reset in the middle of a long write wait
        wait_cfg = 12;
        mdr_fields = {4'd1, 3'd2, 3'd0, 3'd0};
        repeat (20) @(negedge clk);
        #2;
        chk("R3", "still writing during wait", mem_wr, 1);
        rst_n = 1'b0;
        #1;
        chk("R1", "state after mid-wait reset", state_code, 0);
        chk("R1", "write dropped by reset", mem_wr, 0);
        repeat (2) @(negedge clk);
        #1;
        wait_cfg = 0;
        rst_n = 1'b1;
        issue("R1", 5, 0, 3, 4, 1'b0, 0);

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule